// File: doc/BRIEF.md
# Request-Paced Block DMA Channel with Strided Destination

This block is one DMA channel. A peripheral raises a request line when it has results ready. On each accepted request, the channel copies one block of 16-bit words from a small source window, such as a bank of result registers, into memory. The source pointer walks through the window and returns to the window start when the block ends. Each word lands at the destination pointer, which then moves forward by a programmable byte stride instead of the word size.

Because of the stride, several channels can share one array, each filling its own column. A 6-byte stride lets three such channels interleave their words.

A total byte count limits the whole job. When the count runs out, the channel does three things:

- it raises an end flag,
- it drops its own enable,
- it can request an interrupt.

Software loads the channel through a small word-addressed register port. The channel moves data as a bus master on a simple memory bus with a ready handshake. Each word takes one read cycle followed by one write cycle.

Top module: `dma_blk_chan`

## Requirements
- R1: After reset, every register reads 0, `mem_req_o`, `ack_o` and `irq_o` are 0, and no bus cycle starts.
- R2: When the enable bit is 1 and `req_i` is 1 while the channel is idle, the channel moves one block. The block has as many words as the working block count. Each word is one read of the source address followed by one write to the destination address, and the write carries the data that was read.
- R3: The source address rises by 2 after every word. After the last word of a block, it returns to the value it had when the block started.
- R4: After every word, the destination address rises by the stride register value.
- R5: The count register (offset 3) drops by 2 per word. When a word leaves it at 0, the channel does three things: it sets the end flag, clears the enable bit, and ends the block early even if words remain. The source and working count then stay at their mid-block values.
- R6: `irq_o` is 1 exactly when both the end flag and the interrupt-enable bit are 1. Clearing either bit lowers it.
- R7: The end flag clears in two cases. The first is a control write with bit 0 = 1. The second is a control write with bit 1 = 0 that follows a control read which returned bit 1 = 1. A control write with bit 1 = 0 and no such read leaves the flag set. Software writes of 1 to bit 1 never set it.
- R8: When the acknowledge bit is 1, `ack_o` pulses for the one cycle in which a request is accepted. When the bit is 0, `ack_o` stays 0.
- R9: While `mem_req_o` is 1 and `mem_ready_i` is 0, the address, direction and write data hold steady.
- R10: While the enable bit is 0, requests start no bus cycle.
- R11: The block register (offset 4) holds the reload value in bits 31:16 and the working count in bits 15:0. After the last word of a block, the working count reloads from bits 31:16; otherwise it drops by 1 per word.
- R12: Register map, by `cfg_addr_i`:
  - 0: source
  - 1: destination
  - 2: stride
  - 3: count
  - 4: block
  - 5: control, with bit 0 = enable, bit 1 = end flag, bit 2 = interrupt enable, bit 3 = acknowledge enable

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_re_i | input | 1 | Register read strobe (arms the flag clear) |
| cfg_addr_i | input | 3 | Register select |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data, same cycle |
| req_i | input | 1 | Peripheral transfer request |
| ack_o | output | 1 | Request acknowledge pulse |
| irq_o | output | 1 | Transfer-end interrupt |
| mem_req_o | output | 1 | Bus cycle request |
| mem_we_o | output | 1 | 1 for a write cycle, 0 for a read cycle |
| mem_addr_o | output | 32 | Bus byte address |
| mem_wdata_o | output | 16 | Bus write data |
| mem_rdata_i | input | 16 | Bus read data |
| mem_ready_i | input | 1 | Bus cycle completes on this cycle |

## Verification
The hardest state to reach is a count that runs out in the middle of a block. In that state the source and working count are left partway through the window, and the end flag clears only through its read-then-write path.

The stimulus loads a 4-byte count against a 4-word block, so the job ends after two words. The bench then reads back the stranded source and working count. Next it sets the interrupt enable while leaving the flag set, and finally clears the flag through the enable bit.

A ready line that stalls every third cycle keeps the handshake hold exercised on both reads and writes.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} eng_state_e;

  localparam logic [2:0] REG_SRC = 3'd0;
  localparam logic [2:0] REG_DST = 3'd1;
  localparam logic [2:0] REG_OFS = 3'd2;
  localparam logic [2:0] REG_CNT = 3'd3;
  localparam logic [2:0] REG_BLK = 3'd4;
  localparam logic [2:0] REG_CTL = 3'd5;

  localparam int CTL_EN  = 0;
  localparam int CTL_END = 1;
  localparam int CTL_IE  = 2;
  localparam int CTL_ACK = 3;
endpackage

// File: rtl/dma_blk_regs.sv
module dma_blk_regs
  import dma_blk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_re_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  output logic [ADDR_W-1:0] cfg_rdata_o,
  input  logic              blk_start_i,
  input  logic              word_done_i,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [ADDR_W-1:0] cnt_o,
  output logic [ADDR_W/2-1:0] blkw_o,
  output logic              en_o,
  output logic              ack_en_o,
  output logic              flag_o,
  output logic              irq_o
);
  localparam int HALF = ADDR_W / 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);
  localparam logic [HALF-1:0]   ONE_H = HALF'(1);

  logic [ADDR_W-1:0] src_q, dst_q, ofs_q, cnt_q, base_q;
  logic [HALF-1:0]   rl_q, wk_q;
  logic              en_q, flag_q, ie_q, ack_q, armed_q;
  logic              blk_last, cnt_last;

  assign blk_last = (wk_q <= ONE_H);
  assign cnt_last = (cnt_q <= STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0; dst_q <= '0; ofs_q <= '0; cnt_q <= '0; base_q <= '0;
      rl_q <= '0; wk_q <= '0;
      en_q <= 1'b0; flag_q <= 1'b0; ie_q <= 1'b0; ack_q <= 1'b0; armed_q <= 1'b0;
    end else begin
      if (cfg_re_i && !cfg_we_i && cfg_addr_i == REG_CTL && flag_q) armed_q <= 1'b1;
      if (cfg_we_i) begin
        case (cfg_addr_i)
          REG_SRC: src_q <= cfg_wdata_i;
          REG_DST: dst_q <= cfg_wdata_i;
          REG_OFS: ofs_q <= cfg_wdata_i;
          REG_CNT: cnt_q <= cfg_wdata_i;
          REG_BLK: begin
            rl_q <= cfg_wdata_i[ADDR_W-1:HALF];
            wk_q <= cfg_wdata_i[HALF-1:0];
          end
          REG_CTL: begin
            en_q    <= cfg_wdata_i[CTL_EN];
            ie_q    <= cfg_wdata_i[CTL_IE];
            ack_q   <= cfg_wdata_i[CTL_ACK];
            armed_q <= 1'b0;
            // clear by enabling, or by writing 0 after reading the flag set
            if (cfg_wdata_i[CTL_EN] || (!cfg_wdata_i[CTL_END] && armed_q)) flag_q <= 1'b0;
          end
          default: ;
        endcase
      end
      if (blk_start_i) base_q <= src_q;
      if (word_done_i) begin
        dst_q <= dst_q + ofs_q;
        src_q <= blk_last ? base_q : src_q + STEP;
        wk_q  <= blk_last ? rl_q : wk_q - ONE_H;
        if (cnt_last) begin
          cnt_q  <= '0;
          flag_q <= 1'b1;
          en_q   <= 1'b0;
        end else begin
          cnt_q <= cnt_q - STEP;
        end
      end
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    case (cfg_addr_i)
      REG_SRC: cfg_rdata_o = src_q;
      REG_DST: cfg_rdata_o = dst_q;
      REG_OFS: cfg_rdata_o = ofs_q;
      REG_CNT: cfg_rdata_o = cnt_q;
      REG_BLK: cfg_rdata_o = {rl_q, wk_q};
      REG_CTL: begin
        cfg_rdata_o[CTL_EN]  = en_q;
        cfg_rdata_o[CTL_END] = flag_q;
        cfg_rdata_o[CTL_IE]  = ie_q;
        cfg_rdata_o[CTL_ACK] = ack_q;
      end
      default: ;
    endcase
  end

  assign src_o    = src_q;
  assign dst_o    = dst_q;
  assign cnt_o    = cnt_q;
  assign blkw_o   = wk_q;
  assign en_o     = en_q;
  assign ack_en_o = ack_q;
  assign flag_o   = flag_q;
  assign irq_o    = flag_q & ie_q;
endmodule

// File: rtl/dma_blk_engine.sv
module dma_blk_engine
  import dma_blk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                en_i,
  input  logic                ack_en_i,
  input  logic [ADDR_W-1:0]   src_i,
  input  logic [ADDR_W-1:0]   dst_i,
  input  logic [ADDR_W-1:0]   cnt_i,
  input  logic [ADDR_W/2-1:0] blkw_i,
  input  logic                mem_ready_i,
  input  logic [WORD_W-1:0]   mem_rdata_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [WORD_W-1:0]   mem_wdata_o,
  output logic                ack_o,
  output logic                blk_start_o,
  output logic                word_done_o
);
  localparam int HALF = ADDR_W / 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);
  localparam logic [HALF-1:0]   ONE_H = HALF'(1);

  eng_state_e        state_q;
  logic [WORD_W-1:0] data_q;
  logic              start, last;

  assign start = (state_q == ST_IDLE) && en_i && req_i;
  assign last  = (blkw_i <= ONE_H) || (cnt_i <= STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) state_q <= ST_RD;
        ST_RD: if (mem_ready_i) begin
          data_q  <= mem_rdata_i;
          state_q <= ST_WR;
        end
        ST_WR: if (mem_ready_i) state_q <= last ? ST_IDLE : ST_RD;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (state_q != ST_IDLE);
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_addr_o  = (state_q == ST_WR) ? dst_i : src_i;
  assign mem_wdata_o = data_q;
  assign ack_o       = start && ack_en_i;
  assign blk_start_o = start;
  assign word_done_o = (state_q == ST_WR) && mem_ready_i;
endmodule

// File: rtl/dma_blk_chan.sv
module dma_blk_chan #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_re_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  output logic [ADDR_W-1:0] cfg_rdata_o,
  input  logic              req_i,
  output logic              ack_o,
  output logic              irq_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i
);
  logic [ADDR_W-1:0]   src_w, dst_w, cnt_w;
  logic [ADDR_W/2-1:0] blkw_w;
  logic                en_w, ack_en_w, flag_w, blk_start_w, word_done_w;

  dma_blk_regs #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_re_i, .cfg_addr_i, .cfg_wdata_i, .cfg_rdata_o,
    .blk_start_i(blk_start_w), .word_done_i(word_done_w),
    .src_o(src_w), .dst_o(dst_w), .cnt_o(cnt_w), .blkw_o(blkw_w),
    .en_o(en_w), .ack_en_o(ack_en_w), .flag_o(flag_w), .irq_o
  );

  dma_blk_engine #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_eng (
    .clk_i, .rst_ni, .req_i, .en_i(en_w), .ack_en_i(ack_en_w),
    .src_i(src_w), .dst_i(dst_w), .cnt_i(cnt_w), .blkw_i(blkw_w),
    .mem_ready_i, .mem_rdata_i, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .ack_o, .blk_start_o(blk_start_w), .word_done_o(word_done_w)
  );
endmodule

// File: rtl/dma_blk_chan_chk.sv
module dma_blk_chan_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              ack_o,
  input logic              irq_o,
  input logic              en_q,
  input logic              flag_q,
  input logic              word_done,
  input logic [ADDR_W-1:0] cnt_q
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

  assert_hold_bus_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  assert_read_then_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && mem_ready_i |=> mem_req_o && mem_we_o);

  assert_ack_starts_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> mem_req_o && !mem_we_o);

  assert_count_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_done && (cnt_q <= STEP) |=> flag_q && !en_q);

  assert_idle_when_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q && !mem_req_o |=> !mem_req_o);

  assert_irq_needs_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_q);
endmodule

bind dma_blk_chan dma_blk_chan_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .mem_req_o, .mem_we_o, .mem_ready_i, .mem_addr_o, .ack_o, .irq_o,
  .en_q(en_w), .flag_q(flag_w), .word_done(word_done_w), .cnt_q(cnt_w)
);

// File: tb/dma_blk_chan_tb_top.sv
module dma_blk_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_re = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        req = 1'b0, ack, irq;
  logic        mem_req, mem_we, mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  int n_tests = 0, n_fail = 0, n_ack = 0, n_words = 0, cyc = 0;
  bit done = 0;

  // behavioural model
  longint m_src, m_base, m_dst, m_ofs, m_cnt, m_blkw, m_rl;
  bit m_inblk = 0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] src_val(logic [31:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction
  assign mem_rdata = src_val(mem_addr);

  dma_blk_chan dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_re_i(cfg_re), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .req_i(req), .ack_o(ack), .irq_o(irq),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready)
  );

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // bus responder and model comparison, every clock
  always @(negedge clk) begin
    bit rdy, last;
    cyc++;
    rdy = (cyc % 3) != 2;
    mem_ready = rdy;
    if (rst_n && mem_req && rdy) begin
      if (!mem_we) begin
        if (!m_inblk) begin m_base = m_src; m_inblk = 1; end
        chk(mem_addr == m_src[31:0], "R3 read address", mem_addr, m_src);
      end else begin
        chk(mem_addr == m_dst[31:0], "R4 write address", mem_addr, m_dst);
        chk(mem_wdata == src_val(m_src[31:0]), "R2 write data", mem_wdata, src_val(m_src[31:0]));
        n_words++;
        last = 0;
        m_dst = (m_dst + m_ofs) & 32'hFFFF_FFFF;
        if (m_blkw <= 1) begin m_src = m_base; m_blkw = m_rl; last = 1; end
        else begin m_src = m_src + 2; m_blkw--; end
        if (m_cnt <= 2) begin m_cnt = 0; last = 1; end else m_cnt -= 2;
        if (last) m_inblk = 0;
      end
    end
  end

  task automatic cfg_write(logic [2:0] a, logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_read(logic [2:0] a, output logic [31:0] d);
    cfg_re = 1; cfg_addr = a;
    #1 d = cfg_rdata;
    @(posedge clk); @(negedge clk);
    cfg_re = 0;
  endtask

  task automatic load(longint s, longint d, longint o, longint c, logic [31:0] b);
    cfg_write(3'd0, s[31:0]); cfg_write(3'd1, d[31:0]); cfg_write(3'd2, o[31:0]);
    cfg_write(3'd3, c[31:0]); cfg_write(3'd4, b);
    m_src = s; m_dst = d; m_ofs = o; m_cnt = c; m_rl = b[31:16]; m_blkw = b[15:0]; m_inblk = 0;
  endtask

  task automatic request();
    req = 1;
    #1 if (ack) n_ack++;
    @(posedge clk); @(negedge clk);
    req = 0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 4) begin
      @(negedge clk);
      quiet = mem_req ? 0 : quiet + 1;
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] rd;
    int words0, acks0, busy;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      cfg_read(3'(a), rd);
      chk(rd == 0, "R1 reset register", rd, 0);
    end
    chk(!mem_req && !irq && !ack, "R1 outputs idle", {mem_req, irq, ack}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    cfg_read(3'd5, rd);
    chk(rd == 0, "R1 control after reset", rd, 0);

    // R2 R3 R4 R11 R12: six blocks of four words, stride 6, ack on
    load(32'h1000, 32'h8000, 6, 48, 32'h0004_0004);
    cfg_write(3'd5, 32'hD);
    for (int b = 0; b < 6; b++) begin
      request();
      wait_idle();
      chk(n_words == 4 * (b + 1), "R2 words per block", n_words, 4 * (b + 1));
    end
    chk(n_ack == 6, "R8 ack per request", n_ack, 6);
    chk(irq == 1, "R6 irq on end", irq, 1);
    cfg_read(3'd0, rd); chk(rd == 32'h1000, "R3 source back at base", rd, 32'h1000);
    cfg_read(3'd1, rd); chk(rd == 32'h8090, "R4 destination strided", rd, 32'h8090);
    cfg_read(3'd3, rd); chk(rd == 0, "R5 count zero", rd, 0);
    cfg_read(3'd4, rd); chk(rd == 32'h0004_0004, "R11 block reloaded", rd, 32'h0004_0004);

    // R10: request while disabled
    words0 = n_words; acks0 = n_ack; busy = 0;
    request();
    repeat (20) begin @(negedge clk); if (mem_req) busy++; end
    chk(busy == 0 && n_words == words0, "R10 no cycle when disabled", busy, 0);
    chk(n_ack == acks0, "R10 no ack when disabled", n_ack, acks0);

    // R7: write 0 to flag without a prior read keeps it
    cfg_write(3'd5, 32'h4);
    @(negedge clk);
    chk(irq == 1, "R7 unarmed write keeps flag", irq, 1);
    cfg_read(3'd5, rd); chk(rd == 32'h6, "R7 flag reads set", rd, 32'h6);
    cfg_write(3'd5, 32'h4);
    @(negedge clk);
    chk(irq == 0, "R7 read then write 0 clears flag", irq, 0);

    // R5: count ends mid-block, interrupt disabled
    load(32'h2000, 32'h9000, 6, 4, 32'h0004_0004);
    cfg_write(3'd5, 32'h9);
    words0 = n_words;
    request();
    wait_idle();
    chk(n_words - words0 == 2, "R5 early stop words", n_words - words0, 2);
    chk(irq == 0, "R6 no irq when disabled", irq, 0);
    cfg_read(3'd5, rd); chk(rd == 32'hA, "R5 flag set enable cleared", rd, 32'hA);
    cfg_read(3'd0, rd); chk(rd == 32'h2004, "R5 source left mid-block", rd, 32'h2004);
    cfg_read(3'd4, rd); chk(rd == 32'h0004_0002, "R11 working count mid-block", rd, 32'h0004_0002);
    cfg_write(3'd5, 32'h6);
    @(negedge clk);
    chk(irq == 1, "R6 irq after enabling interrupt", irq, 1);
    cfg_write(3'd5, 32'h5);
    @(negedge clk);
    chk(irq == 0, "R7 enable write clears flag", irq, 0);
    cfg_write(3'd5, 32'h4);

    // R8: ack disabled, stride 2
    load(32'h3000, 32'hA000, 2, 8, 32'h0004_0004);
    cfg_write(3'd5, 32'h1);
    words0 = n_words; acks0 = n_ack;
    request();
    wait_idle();
    chk(n_ack == acks0, "R8 no ack when option off", n_ack, acks0);
    chk(n_words - words0 == 4, "R2 block with ack off", n_words - words0, 4);
    cfg_read(3'd1, rd); chk(rd == 32'hA008, "R4 stride 2", rd, 32'hA008);
    cfg_read(3'd5, rd); chk(rd == 32'h2, "R5 end flag", rd, 32'h2);

    done = 1;
    finish_run();
  end
endmodule